// File: doc/BRIEF.md
# Unit-Range Fixed-Point Clamp

This block sits after a normalising step, such as a square root or a divide whose result should fall between -1 and +1. Rounding error in that step can push the result slightly past either bound. The block takes a sign bit, an out-of-range flag and a wide fraction. It registers a sign bit and a narrower fraction, and it forces any out-of-range value back to the nearest value the output can represent.

The output encodes the value -s + f / 2^OUT_FRAC_W, where s is `sgn_out` and f is `frac_out`. The input flag `ovf_in` is the lowest bit of the integer part of the incoming value. When it is high, the magnitude has reached or passed one. Saturation is asymmetric. A positive overshoot becomes the largest fraction below one, which is 0.999023 with the default widths. A negative overshoot becomes exactly -1. In-range values are truncated with no rounding.

Top module: `unit_clamp`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the output register clears, so `sgn_out` = 0 and `frac_out` = 0 after that edge.
- R2: With `en` high, the output reflects the inputs sampled at a rising edge and changes at that edge only, which gives one cycle of latency.
- R3: With `en` low and `rst_n` high, `sgn_out` and `frac_out` keep their values at every edge, whatever the other inputs do.
- R4: With `ovf_in` = 0, `frac_out` equals bits [IN_FRAC_W-1 : IN_FRAC_W-OUT_FRAC_W] of `frac_in`. The lower bits are dropped with no rounding.
- R5: With `ovf_in` = 0, `sgn_out` equals `sgn_in`, for both positive and negative inputs.
- R6: With `ovf_in` = 1 and `sgn_in` = 0, the output is `sgn_out` = 0 with every bit of `frac_out` set, which is the largest value below +1.
- R7: With `ovf_in` = 1 and `sgn_in` = 1, the output is `sgn_out` = 1 with `frac_out` all zero, which encodes exactly -1.
- R8: With `ovf_in` = 1, the value of `frac_in` has no effect on the output.
- R9: Reset takes effect even while `en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Clock enable for the output register |
| sgn_in | input | 1 | Sign bit of the incoming value |
| ovf_in | input | 1 | Lowest integer bit of the incoming value; high means the magnitude is at or beyond one |
| frac_in | input | IN_FRAC_W | Incoming fraction, 16 bits by default |
| sgn_out | output | 1 | Registered output sign |
| frac_out | output | OUT_FRAC_W | Registered output fraction, 10 bits by default |

## Verification
The checker evaluates every cycle. It covers the clear after reset, the hold while the enable is low, the one-cycle pass-through of the sign and the truncated fraction, and both saturation directions, each against the inputs of the previous cycle. Some properties need a chosen sequence of stimulus and can only be shown by the bench scenarios. These are: that bits below the kept field really are discarded without rounding, that the fraction is ignored during saturation, that the output does not move before the clock edge, and that reset wins over a low enable.

// File: rtl/uclamp_pkg.sv
// Package: shared selection type and decode for the unit-range clamp.
// Assumes the out-of-range flag means the magnitude is at or beyond one.
package uclamp_pkg;

    typedef enum logic [1:0] {
        SEL_PASS    = 2'd0,
        SEL_POS_MAX = 2'd1,
        SEL_NEG_ONE = 2'd2
    } clamp_sel_e;

    // Decide the output source from the sign and the out-of-range flag.
    function automatic clamp_sel_e pick_sel(input logic sgn, input logic ovf);
        clamp_sel_e s;
        if (!ovf)
            s = SEL_PASS;
        else if (sgn)
            s = SEL_NEG_ONE;
        else
            s = SEL_POS_MAX;
        return s;
    endfunction

endpackage

// File: rtl/uclamp_trunc.sv
// Module: narrows a fraction to its top OUT_W bits by truncation.
// Assumes OUT_W is at least 1. If OUT_W exceeds IN_W, the fraction is
// widened with zero bits on the right instead.
module uclamp_trunc #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 10
) (
    input  logic [IN_W-1:0]  frac_i,
    output logic [OUT_W-1:0] frac_o
);
    generate
        if (OUT_W < IN_W) begin : g_narrow
            localparam int DROP_W = IN_W - OUT_W;
            logic unused_low;
            // Keep the upper bits and discard the rest.
            assign frac_o     = frac_i[IN_W-1:DROP_W];
            assign unused_low = ^frac_i[DROP_W-1:0];
        end else if (OUT_W == IN_W) begin : g_same
            // Widths match, so pass straight through.
            assign frac_o = frac_i;
        end else begin : g_widen
            localparam int PAD_W = OUT_W - IN_W;
            // Pad the low end with zeros.
            assign frac_o = {frac_i, {PAD_W{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/uclamp_sat.sv
// Module: chooses between the truncated fraction and the two saturation
// values. Purely combinational; the caller supplies the selection.
module uclamp_sat
    import uclamp_pkg::*;
#(
    parameter int OUT_W = 10
) (
    input  clamp_sel_e       sel_i,
    input  logic             sgn_i,
    input  logic [OUT_W-1:0] frac_i,
    output logic             sgn_o,
    output logic [OUT_W-1:0] frac_o
);
    // Drive the sign and fraction for the chosen source.
    always_comb begin
        unique case (sel_i)
            SEL_POS_MAX: begin
                sgn_o  = 1'b0;
                frac_o = {OUT_W{1'b1}};
            end
            SEL_NEG_ONE: begin
                sgn_o  = 1'b1;
                frac_o = {OUT_W{1'b0}};
            end
            default: begin
                sgn_o  = sgn_i;
                frac_o = frac_i;
            end
        endcase
    end
endmodule

// File: rtl/uclamp_oreg.sv
// Module: output register with a clock enable and a synchronous
// active-low clear. The clear ignores the enable.
module uclamp_oreg #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Clear on reset, otherwise load when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (en)
            q <= d;
    end
endmodule

// File: rtl/unit_clamp.sv
// Module: unit-range fixed-point clamp. It truncates the fraction,
// saturates values at or beyond one in magnitude, and registers the
// result. Assumes ovf_in is the lowest integer bit of the incoming value.
module unit_clamp
    import uclamp_pkg::*;
#(
    parameter int IN_FRAC_W  = 16,
    parameter int OUT_FRAC_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  sgn_in,
    input  logic                  ovf_in,
    input  logic [IN_FRAC_W-1:0]  frac_in,
    output logic                  sgn_out,
    output logic [OUT_FRAC_W-1:0] frac_out
);
    localparam int REG_W = OUT_FRAC_W + 1;

    clamp_sel_e            sel;
    logic [OUT_FRAC_W-1:0] frac_cut;
    logic                  sgn_nxt;
    logic [OUT_FRAC_W-1:0] frac_nxt;
    logic [REG_W-1:0]      reg_q;

    // Decode which output source applies this cycle.
    always_comb sel = pick_sel(sgn_in, ovf_in);

    uclamp_trunc #(.IN_W(IN_FRAC_W), .OUT_W(OUT_FRAC_W)) u_trunc (
        .frac_i (frac_in),
        .frac_o (frac_cut)
    );

    uclamp_sat #(.OUT_W(OUT_FRAC_W)) u_sat (
        .sel_i  (sel),
        .sgn_i  (sgn_in),
        .frac_i (frac_cut),
        .sgn_o  (sgn_nxt),
        .frac_o (frac_nxt)
    );

    uclamp_oreg #(.W(REG_W)) u_oreg (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .d     ({sgn_nxt, frac_nxt}),
        .q     (reg_q)
    );

    assign sgn_out  = reg_q[REG_W-1];
    assign frac_out = reg_q[OUT_FRAC_W-1:0];
endmodule

// File: rtl/unit_clamp_chk.sv
// Module: property checker for unit_clamp, attached by bind. It relates
// the registered outputs to the inputs of the previous cycle.
module unit_clamp_chk #(
    parameter int IN_FRAC_W  = 16,
    parameter int OUT_FRAC_W = 10
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  en,
    input logic                  sgn_in,
    input logic                  ovf_in,
    input logic [IN_FRAC_W-1:0]  frac_in,
    input logic                  sgn_out,
    input logic [OUT_FRAC_W-1:0] frac_out
);
    logic                  past_valid = 1'b0;
    logic [OUT_FRAC_W-1:0] top_ref;

    // Mark that at least one edge has occurred.
    always_ff @(posedge clk) past_valid <= 1'b1;

    generate
        if (OUT_FRAC_W <= IN_FRAC_W) begin : g_ref_cut
            assign top_ref = frac_in[IN_FRAC_W-1 -: OUT_FRAC_W];
        end else begin : g_ref_pad
            assign top_ref = {frac_in, {(OUT_FRAC_W-IN_FRAC_W){1'b0}}};
        end
    endgenerate

    // R1 R9
    reset_clear_chk: assert property (@(posedge clk)
        (past_valid && $past(!rst_n)) |-> (sgn_out == 1'b0 && frac_out == '0));

    // R3
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(rst_n) && $past(!en)) |-> ($stable(sgn_out) && $stable(frac_out)));

    // R2 R4 R5
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(rst_n && en && !ovf_in))
        |-> (sgn_out == $past(sgn_in) && frac_out == $past(top_ref)));

    // R6
    pos_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(rst_n && en && ovf_in && !sgn_in))
        |-> (sgn_out == 1'b0 && frac_out == {OUT_FRAC_W{1'b1}}));

    // R7
    neg_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(rst_n && en && ovf_in && sgn_in))
        |-> (sgn_out == 1'b1 && frac_out == '0));
endmodule

bind unit_clamp unit_clamp_chk #(
    .IN_FRAC_W  (IN_FRAC_W),
    .OUT_FRAC_W (OUT_FRAC_W)
) u_chk (.*);

// File: tb/unit_clamp_tb.sv
`timescale 1ns/1ps
module unit_clamp_tb;
    localparam int IW = 16;
    localparam int OW = 10;
    localparam int NV = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          sgn_in = 1'b0;
    logic          ovf_in = 1'b0;
    logic [IW-1:0] frac_in = '0;
    logic          sgn_out;
    logic [OW-1:0] frac_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Vector fields: [28] sign, [27] ovf, [26:11] fraction in,
    // [10] expected sign, [9:0] expected fraction.
    localparam logic [28:0] VEC [NV] = '{
        {1'b0, 1'b0, 16'hFFFF, 1'b0, 10'h3FF},  // R4 truncation just below one
        {1'b0, 1'b0, 16'h8040, 1'b0, 10'h201},  // R4 mid pattern
        {1'b0, 1'b0, 16'h003F, 1'b0, 10'h000},  // R4 only dropped bits set
        {1'b1, 1'b0, 16'hC000, 1'b1, 10'h300},  // R5 negative in range
        {1'b0, 1'b1, 16'h0000, 1'b0, 10'h3FF},  // R6 positive overshoot
        {1'b0, 1'b1, 16'h1234, 1'b0, 10'h3FF},  // R6 R8 fraction ignored
        {1'b1, 1'b1, 16'hFFFF, 1'b1, 10'h000},  // R7 R8 fraction ignored
        {1'b1, 1'b1, 16'h0000, 1'b1, 10'h000},  // R7 negative overshoot
        {1'b1, 1'b0, 16'h0040, 1'b1, 10'h001}   // R5 small negative step
    };
    localparam string VREQ [NV] = '{"R4", "R4", "R4", "R5", "R6", "R8", "R8", "R7", "R5"};

    unit_clamp #(.IN_FRAC_W(IW), .OUT_FRAC_W(OW)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .sgn_in   (sgn_in),
        .ovf_in   (ovf_in),
        .frac_in  (frac_in),
        .sgn_out  (sgn_out),
        .frac_out (frac_out)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [OW:0] exp);
        checks++;
        if ({sgn_out, frac_out} !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, {sgn_out, frac_out}, exp);
        end
    endtask

    task automatic drive(input logic s, input logic o, input logic [IW-1:0] f);
        sgn_in  = s;
        ovf_in  = o;
        frac_in = f;
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", '0);
        rst_n = 1'b1;
        en    = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][28], VEC[i][27], VEC[i][26:11]);
            @(negedge clk);
            check(VREQ[i], VEC[i][10:0]);
        end

        // R2: the output does not change before the edge, then takes the new value.
        drive(1'b0, 1'b0, 16'h5555);
        #2;
        check("R2", {1'b1, 10'h001});
        @(negedge clk);
        check("R2", {1'b0, 10'h155});

        // R3: with the enable low the output holds through changing inputs.
        en = 1'b0;
        drive(1'b0, 1'b1, 16'h0000);
        @(negedge clk);
        check("R3", {1'b0, 10'h155});
        drive(1'b1, 1'b1, 16'hAAAA);
        @(negedge clk);
        check("R3", {1'b0, 10'h155});
        en = 1'b1;
        @(negedge clk);
        check("R3", {1'b1, 10'h000});

        // R9: reset clears the output even with the enable low.
        drive(1'b0, 1'b1, 16'h0000);
        @(negedge clk);
        check("R6", {1'b0, 10'h3FF});
        en    = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", '0);
        rst_n = 1'b1;
        en    = 1'b1;
        @(negedge clk);
        check("R6", {1'b0, 10'h3FF});

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule